// File: doc/BRIEF.md
# Randomized Transmission Scheduler

This block decides when a battery-less identification tag sends its identity code. A delay counter advances on bit-rate ticks and is compared with a pseudo-random number on a selectable number of low bits. When the two agree, the block pulses `tx_start` to the code encoder, steps the random generator and clears the counter, so the next gap between transmissions has a new random length.

The block also applies the reader's commands once a gap detector has decoded them. An acknowledge that arrives while the tag is transmitting either shuts the tag down until power is removed or slows its delay counter. A mute puts the tag into a timed nap. A wake-up ends that nap early. The configuration word and the random seed are captured once, on the first clock after reset. All pins are plain control strobes and levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

State encoding on `sched_state`: 0 = boot, 1 = waiting (counting the delay), 2 = sending, 3 = napping, 4 = shut down.

Top module: `xmit_sched`

## Requirements
- R1: While reset is held, `sched_state` is 0. On the first clock edge after reset is released, the block captures `cfg_word` and `seed_word` and moves to state 1.
- R2: The random value comes from a 16-bit LFSR. Its next value is {r[14:0], r[15]^r[13]^r[12]^r[10]}. A seed of zero is replaced by 16'h0001. The LFSR steps once on each transmission start.
- R3: `cfg_word[5:3]` selects how many low bits are compared: 0, 4, 6, 8, 10, 12, 14 or 16 for the values 0 to 7. When the compared bits of the counter and the random value are equal in state 1, `tx_start` is high for exactly one cycle, the state becomes 2 in that same cycle, and the counter is cleared.
- R4: With a delay setting of 0, a transmission starts on the cycle after the block enters state 1, without any tick.
- R5: In state 1 the counter advances by one for each `bit_tick` sampled. `tx_start` rises one cycle after the edge that samples the tick that produces a match.
- R6: In state 2, `tx_done` returns the block to state 1.
- R7: An `ev_ack` in state 2 with `cfg_word[2]`=1 moves the block to state 4. It stays there, and `tx_start` never rises again until reset.
- R8: An `ev_ack` in state 2 with `cfg_word[2]`=0 returns the block to state 1. From then on the counter advances on only one tick in every 8.
- R9: An `ev_mute` in state 1 with `cfg_word[0]`=1 moves the block to state 3. The block returns to state 1 on the 128th tick after the most recent mute. Each further mute restarts the 128-tick count. The counter keeps its value while the block naps.
- R10: An `ev_wake` in state 3 returns the block to state 1 on the next edge.
- R11: With `cfg_word[1]`=1, `ev_ack`, `ev_mute` and `ev_wake` have no effect.
- R12: A mute has no effect when `cfg_word[0]`=0. A mute or wake-up in state 2 has no effect. A wake-up in state 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 16 | Configuration word, captured at boot |
| seed_word | input | 16 | Random seed, captured at boot |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| ev_ack | input | 1 | Decoded acknowledge strobe |
| ev_mute | input | 1 | Decoded mute strobe |
| ev_wake | input | 1 | Decoded wake-up strobe |
| tx_done | input | 1 | Encoder finished the current code |
| tx_start | output | 1 | One-cycle pulse that starts a transmission |
| sched_state | output | 3 | Scheduler state (encoding above) |

## Verification
The assertions check the rules that can be stated as state transitions on every cycle:
- boot always leads to waiting;
- a start pulse lasts one cycle and coincides with the sending state;
- shutdown is permanent;
- a nap ends only in the waiting state;
- free-running mode never naps;
- a zero delay setting starts at once.

Only the directed scenarios can show the quantities that need a reference model: the tick count before each start for a given seed and mask, the eight-fold slowdown after an acknowledge, the exact 128-tick nap and how a later mute restarts it, and the counter value that survives a nap.

// File: rtl/xs_pkg.sv
package xs_pkg;

  typedef enum logic [2:0] {
    ST_BOOT = 3'd0,
    ST_IDLE = 3'd1,
    ST_SEND = 3'd2,
    ST_NAP  = 3'd3,
    ST_DEAD = 3'd4
  } st_e;

  localparam int SEL_W = 3;

  // low six bits of the configuration word, MSB first
  typedef struct packed {
    logic [SEL_W-1:0] dly_sel;
    logic             swoff;
    logic             freerun;
    logic             fast;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // compared width: 0 for setting 0, else 2 + 2*setting, capped at w
  function automatic logic [15:0] mask_of(input logic [SEL_W-1:0] sel, input int w);
    int n;
    logic [15:0] m;
    n = (sel == '0) ? 0 : 2 + 2 * int'(sel);
    if (n > w) n = w;
    for (int i = 0; i < 16; i++) m[i] = (i < n);
    return m;
  endfunction

endpackage

// File: rtl/xs_lfsr.sv
module xs_lfsr #(
  parameter int          W        = 16,
  parameter logic [W-1:0] TAPS    = 16'hB400,
  parameter logic [W-1:0] FALLBACK = 16'h0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] r;
  logic         fb;

  assign fb    = ^(r & TAPS);
  assign value = r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r <= FALLBACK;
    else if (load)  r <= (seed == '0) ? FALLBACK : seed;
    else if (step)  r <= {r[W-2:0], fb};
  end
endmodule

// File: rtl/xs_delay.sv
module xs_delay #(
  parameter int CNT_W = 16,
  parameter int DIV   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    load,
  input  logic                    run,
  input  logic                    tick,
  input  logic                    slow,
  input  logic [xs_pkg::SEL_W-1:0] sel,
  input  logic [CNT_W-1:0]        rnd,
  output logic                    match
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] mask;
  logic [15:0]      mask16;

  assign mask16 = xs_pkg::mask_of(sel, CNT_W);
  assign mask   = mask16[CNT_W-1:0];
  assign match  = ((cnt ^ rnd) & mask) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else if (load) begin
      cnt <= '0;
      pre <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run && tick) begin
      if (!slow) begin
        cnt <= cnt + 1'b1;
      end else if (pre == PRE_LAST) begin
        pre <= '0;
        cnt <= cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xs_ctrl.sv
module xs_ctrl #(
  parameter int SLEEP_TICKS = 128,
  localparam int NAP_W = (SLEEP_TICKS > 1) ? $clog2(SLEEP_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xs_pkg::cfg_t     cfg,
  input  logic             tick,
  input  logic             ev_ack,
  input  logic             ev_mute,
  input  logic             ev_wake,
  input  logic             tx_done,
  input  logic             match,
  output xs_pkg::st_e      state,
  output logic             load,
  output logic             start_go,
  output logic             slow,
  output logic [NAP_W-1:0] nap_cnt
);
  import xs_pkg::*;
  localparam logic [NAP_W-1:0] NAP_LAST = NAP_W'(SLEEP_TICKS - 1);

  st_e  st, nxt;
  logic gap_on, set_slow, nap_clr, nap_inc;

  assign gap_on = !cfg.freerun;
  assign state  = st;

  always_comb begin
    nxt      = st;
    load     = 1'b0;
    start_go = 1'b0;
    set_slow = 1'b0;
    nap_clr  = 1'b0;
    nap_inc  = 1'b0;
    unique case (st)
      ST_BOOT: begin
        load = 1'b1;
        nxt  = ST_IDLE;
      end
      ST_IDLE: begin
        if (gap_on && cfg.fast && ev_mute) begin
          nap_clr = 1'b1;
          nxt     = ST_NAP;
        end else if (match) begin
          start_go = 1'b1;
          nxt      = ST_SEND;
        end
      end
      ST_SEND: begin
        if (gap_on && ev_ack) begin
          if (cfg.swoff) nxt = ST_DEAD;
          else begin
            set_slow = 1'b1;
            nxt      = ST_IDLE;
          end
        end else if (tx_done) begin
          nxt = ST_IDLE;
        end
      end
      ST_NAP: begin
        if (gap_on && ev_mute)      nap_clr = 1'b1;
        else if (gap_on && ev_wake) nxt = ST_IDLE;
        else if (tick) begin
          if (nap_cnt == NAP_LAST) nxt = ST_IDLE;
          else                     nap_inc = 1'b1;
        end
      end
      ST_DEAD: nxt = ST_DEAD;
      default: nxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_BOOT;
      slow    <= 1'b0;
      nap_cnt <= '0;
    end else begin
      st <= nxt;
      if (set_slow) slow <= 1'b1;
      if (nap_clr)      nap_cnt <= '0;
      else if (nap_inc) nap_cnt <= nap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/xmit_sched.sv
module xmit_sched #(
  parameter int CNT_W       = 16,
  parameter int SLOW_DIV    = 8,
  parameter int SLEEP_TICKS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cfg_word,
  input  logic [CNT_W-1:0] seed_word,
  input  logic             bit_tick,
  input  logic             ev_ack,
  input  logic             ev_mute,
  input  logic             ev_wake,
  input  logic             tx_done,
  output logic             tx_start,
  output logic [2:0]       sched_state
);
  import xs_pkg::*;
  localparam int NAP_W = (SLEEP_TICKS > 1) ? $clog2(SLEEP_TICKS) : 1;

  cfg_t             cfg_q;
  st_e              st;
  logic             load, start_go, slow, match;
  logic [CNT_W-1:0] rnd;
  logic [NAP_W-1:0] nap_cnt;
  logic             start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_t'(cfg_word[CFG_W-1:0]);
  end

  xs_lfsr #(.W(CNT_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_word),
    .step(start_go), .value(rnd)
  );

  xs_delay #(.CNT_W(CNT_W), .DIV(SLOW_DIV)) u_delay (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .load(load),
    .run(st == ST_IDLE), .tick(bit_tick), .slow(slow),
    .sel(cfg_q.dly_sel), .rnd(rnd), .match(match)
  );

  xs_ctrl #(.SLEEP_TICKS(SLEEP_TICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .tick(bit_tick),
    .ev_ack(ev_ack), .ev_mute(ev_mute), .ev_wake(ev_wake),
    .tx_done(tx_done), .match(match), .state(st), .load(load),
    .start_go(start_go), .slow(slow), .nap_cnt(nap_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_go;
  end

  assign tx_start    = start_q;
  assign sched_state = st;
endmodule

// File: rtl/xs_sched_chk.sv
module xs_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       tx_start,
  input logic       ev_mute,
  input logic       freerun,
  input logic [2:0] dly_sel
);
  a_r1_boot_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd0 |=> state == 3'd1);

  a_r3_start_in_send: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> state == 3'd2);

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r4_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && dly_sel == 3'd0 && !ev_mute) |=> tx_start);

  a_r7_dead_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 |=> state == 3'd4 && !tx_start);

  a_r9_nap_exit: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd3 |=> (state == 3'd3 || state == 3'd1));

  a_r11_no_nap_freerun: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && freerun) |=> state != 3'd3);
endmodule

bind xmit_sched xs_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(sched_state), .tx_start(tx_start),
  .ev_mute(ev_mute), .freerun(cfg_q.freerun), .dly_sel(cfg_q.dly_sel)
);

// File: tb/xmit_sched_test.sv
module xmit_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = '0, seed_word = '0;
  logic        bit_tick = 0, ev_ack = 0, ev_mute = 0, ev_wake = 0, tx_done = 0;
  logic        tx_start;
  logic [2:0]  sched_state;

  int checks = 0, fails = 0, starts = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xmit_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .seed_word(seed_word),
    .bit_tick(bit_tick), .ev_ack(ev_ack), .ev_mute(ev_mute), .ev_wake(ev_wake),
    .tx_done(tx_done), .tx_start(tx_start), .sched_state(sched_state)
  );

  always @(posedge clk) if (tx_start) starts++;

  function automatic logic [15:0] nxt_rnd(input logic [15:0] r);
    return {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
  endfunction

  function automatic int masked(input logic [15:0] r, input int sel);
    int n = (sel == 0) ? 0 : 2 + 2 * sel;
    return (n >= 16) ? int'(r) : int'(r) & ((1 << n) - 1);
  endfunction

  function automatic logic [15:0] cfgw(input bit fast, input bit fr, input bit so, input int sel);
    return 16'(sel << 3) | {13'd0, so, fr, fast};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1; @(posedge clk); @(negedge clk); bit_tick = 0;
  endtask

  task automatic ev(input int which);
    case (which)
      0: ev_ack = 1; 1: ev_mute = 1; 2: ev_wake = 1; default: tx_done = 1;
    endcase
    @(posedge clk); @(negedge clk);
    ev_ack = 0; ev_mute = 0; ev_wake = 0; tx_done = 0;
  endtask

  task automatic boot(input logic [15:0] c, input logic [15:0] s);
    @(negedge clk); rst_n = 0; cfg_word = c; seed_word = s;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic expect_start(input int k, input string req);
    int base = starts;
    bit early = 0;
    if (k == 0) settle();
    for (int i = 0; i < k; i++) begin
      tick(); settle();
      if (i < k - 1 && starts != base) early = 1;
    end
    chk(!early && starts == base + 1, req, starts - base, 1);
    chk(sched_state == 3'd2, req, sched_state, 2);
  endtask

  task automatic t_boot();
    boot(cfgw(0, 0, 0, 1), 16'hACE1);
    chk(sched_state == 3'd0, "R1", sched_state, 0);
    @(negedge clk);
    chk(sched_state == 3'd1, "R1", sched_state, 1);
  endtask

  task automatic t_delay();
    logic [15:0] r = 16'hACE1;
    boot(cfgw(0, 0, 0, 1), r); @(negedge clk);
    expect_start(masked(r, 1), "R3/R5");
    ev(3);
    chk(sched_state == 3'd1, "R6", sched_state, 1);
    r = nxt_rnd(r);
    expect_start(masked(r, 1), "R2");
  endtask

  task automatic t_zero_seed();
    boot(cfgw(0, 0, 0, 7), 16'h0000); @(negedge clk);
    expect_start(1, "R2 zero seed");
  endtask

  task automatic t_cont();
    int base;
    boot(cfgw(0, 0, 0, 0), 16'h1234);
    base = starts;
    repeat (3) @(negedge clk);
    chk(starts == base + 1, "R4", starts - base, 1);
    ev(3); settle();
    chk(starts == base + 2, "R4", starts - base, 2);
  endtask

  task automatic t_switch_off();
    int base;
    boot(cfgw(0, 0, 1, 0), 16'h1234);
    repeat (3) @(negedge clk);
    ev(0);
    chk(sched_state == 3'd4, "R7", sched_state, 4);
    base = starts;
    ev(3); repeat (5) tick(); settle();
    chk(starts == base && sched_state == 3'd4, "R7", starts - base, 0);
  endtask

  task automatic t_slow();
    logic [15:0] r = 16'hACE1;
    boot(cfgw(0, 0, 0, 1), r); @(negedge clk);
    expect_start(masked(r, 1), "R8 first");
    ev(0);
    chk(sched_state == 3'd1, "R8", sched_state, 1);
    r = nxt_rnd(r);
    expect_start(8 * masked(r, 1), "R8 slowed");
  endtask

  task automatic t_nap();
    boot(cfgw(1, 0, 0, 1), 16'hACE1); @(negedge clk);
    ev(1);
    chk(sched_state == 3'd3, "R9", sched_state, 3);
    repeat (60) tick();
    ev(1);
    repeat (127) tick();
    chk(sched_state == 3'd3, "R9 restart", sched_state, 3);
    tick();
    chk(sched_state == 3'd1, "R9 expiry", sched_state, 1);
    expect_start(1, "R9 counter kept");
  endtask

  task automatic t_wake();
    boot(cfgw(1, 0, 0, 1), 16'hACE1); @(negedge clk);
    ev(1); repeat (5) tick();
    ev(2);
    chk(sched_state == 3'd1, "R10", sched_state, 1);
  endtask

  task automatic t_freerun();
    boot(cfgw(1, 1, 1, 1), 16'hACE1); @(negedge clk);
    ev(1);
    chk(sched_state == 3'd1, "R11 mute", sched_state, 1);
    expect_start(1, "R11");
    ev(0);
    chk(sched_state == 3'd2, "R11 ack", sched_state, 2);
    ev(3);
    chk(sched_state == 3'd1, "R11 done", sched_state, 1);
  endtask

  task automatic t_ignored();
    boot(cfgw(0, 0, 0, 1), 16'hACE1); @(negedge clk);
    ev(1);
    chk(sched_state == 3'd1, "R12 mute slow mode", sched_state, 1);
    ev(2);
    chk(sched_state == 3'd1, "R12 wake idle", sched_state, 1);
    boot(cfgw(1, 0, 0, 1), 16'hACE1); @(negedge clk);
    expect_start(1, "R12");
    ev(1);
    chk(sched_state == 3'd2, "R12 mute send", sched_state, 2);
    ev(2);
    chk(sched_state == 3'd2, "R12 wake send", sched_state, 2);
  endtask

  initial begin
    t_boot();
    t_delay();
    t_zero_seed();
    t_cont();
    t_switch_off();
    t_slow();
    t_nap();
    t_wake();
    t_freerun();
    t_ignored();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule